// File: doc/BRIEF.md
# Real-Time Clock Divider Chain with Rate Select

This block sits behind a real-time clock's timekeeping logic and turns a 32.768 kHz time-base enable into the three timing events the clock needs. A 15-stage binary counter advances once per time-base pulse. Its most significant stage rises once per second, and that edge becomes the update request for the calendar counters. One of its lower stages, chosen by a 4-bit rate code, drives the square-wave pin. The rising edge of that same stage raises the periodic-flag set pulse.

A 3-bit divider-control code decides whether the chain runs, stops with its count frozen, or is held at zero. Releasing the chain from the held state to the run pattern restarts it at zero. The first update request therefore arrives half a second later, and one follows every second after that. The register that holds the rate code, the control code and the square-wave enable is outside the block and drives these inputs directly. So are the timekeeping counters and the interrupt flag storage.

Top module: `rtc_divchain`

## Requirements
- R1: The counter advances on a clock where `tick_en` is high only while `div_ctl` is 3'b010. With any other code, `tick_en` pulses produce no update request and no periodic pulse.
- R2: The rate code picks a square-wave frequency: code 1 gives 256 Hz, code 2 gives 128 Hz, and a code c from 3 to 15 gives 65536/2^c Hz (3 gives 8192 Hz, 6 gives 1024 Hz, 15 gives 2 Hz). The period P is 32768/frequency time-base pulses. The count n is the number of advancing pulses since the chain was last zeroed. `pf_set` is high for exactly one clock, the clock after an advancing pulse that makes n mod P equal P/2. No interrupt enable gates it.
- R3: With rate code 0, `pf_set` never pulses and `sqw_out` stays low.
- R4: With `sqw_en` high and a nonzero rate code, `sqw_out` is high exactly when n mod P is at least P/2. It is valid from the clock after the advancing pulse.
- R5: `upd_req` is high for one clock, the clock after an advancing pulse that makes n mod 32768 equal 16384. This falls 500 ms after the chain is released from zero, and once per second after that.
- R6: A `div_ctl` code of 3'b11x clears the count to zero on every clock and holds it there. Pulses on `tick_en` are ignored while it is held.
- R7: Any `div_ctl` code other than 3'b010 and 3'b11x freezes the count. Returning to 3'b010 continues from the frozen value.
- R8: `sqw_out` is low whenever `sqw_en` is low. While `rst_n` is low, the count is cleared and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-clock pulse at the 32.768 kHz time-base rate |
| div_ctl | input | 3 | Divider control: 010 run, 11x hold at zero, others freeze |
| rate_sel | input | 4 | Rate code selecting the periodic and square-wave tap |
| sqw_en | input | 1 | Square-wave output enable |
| pf_set | output | 1 | One-clock periodic-flag set pulse |
| sqw_out | output | 1 | Square-wave pin level |
| upd_req | output | 1 | One-clock once-per-second update request |

## Verification
The hardest events to reach are the update requests. The first needs 16384 advancing pulses after a release from hold, and the second needs 32768 more, all with the count's phase tracked exactly through earlier stop and hold intervals. The stimulus releases the chain from a hold and then drives an unbroken run of time-base pulses, one every two clocks, past both the half-second and the one-and-a-half-second marks. Along the way it changes the rate code, so the periodic pulse and square wave are checked against the same running count. A reference count kept in the bench predicts every pulse and pin level at each step.

// File: rtl/rtcdiv_pkg.sv
package rtcdiv_pkg;
  localparam int CHAIN_W = 15;
  localparam int RATE_W  = 4;
  localparam int CTL_W   = 3;
  localparam int TAP_W   = $clog2(CHAIN_W);

  typedef enum logic [1:0] {DIV_STOP, DIV_RUN, DIV_HOLD} div_mode_e;

  // Control code to chain mode: 010 runs, 11x holds at zero, rest freeze
  function automatic div_mode_e decode_ctl(input logic [CTL_W-1:0] c);
    if (c == 3'b010)        return DIV_RUN;
    else if (c[2:1] == 2'b11) return DIV_HOLD;
    else                    return DIV_STOP;
  endfunction

  // Rate code to counter stage; stage k toggles at 32768/2^(k+1) Hz
  function automatic logic [TAP_W-1:0] tap_of_rate(input logic [RATE_W-1:0] r);
    case (r)
      4'd0:    return '0;
      4'd1:    return TAP_W'(6);
      4'd2:    return TAP_W'(7);
      default: return TAP_W'(r - 4'd2);
    endcase
  endfunction

  // True when one more increment makes stage k go from 0 to 1
  function automatic logic stage_rises_next(input logic [CHAIN_W-1:0] cnt,
                                            input logic [TAP_W-1:0]   k);
    logic [CHAIN_W-1:0] mask;
    mask = (CHAIN_W'(1) << (k + TAP_W'(1))) - CHAIN_W'(1);
    return (cnt & mask) == (mask >> 1);
  endfunction
endpackage

// File: rtl/div_core.sv
module div_core
  import rtcdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic [CTL_W-1:0]   div_ctl,
  output logic [CHAIN_W-1:0] cnt,
  output logic               adv
);
  div_mode_e mode;

  assign mode = decode_ctl(div_ctl);
  assign adv  = tick_en && (mode == DIV_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (mode == DIV_HOLD) cnt <= '0;
    else if (adv)             cnt <= cnt + CHAIN_W'(1);
  end

  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DIV_HOLD) |=> (cnt == '0));
  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DIV_STOP) |=> $stable(cnt));
  p_no_tick_still_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && mode != DIV_HOLD) |=> $stable(cnt));
endmodule

// File: rtl/tap_rise.sv
module tap_rise
  import rtcdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               en,
  input  logic [CHAIN_W-1:0] cnt,
  input  logic [TAP_W-1:0]   tap,
  output logic               pulse
);
  logic rise_now;

  assign rise_now = adv && en && stage_rises_next(cnt, tap);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= rise_now;
  end

  p_pulse_from_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(adv));
endmodule

// File: rtl/rtc_divchain.sv
module rtc_divchain
  import rtcdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [CTL_W-1:0]  div_ctl,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqw_en,
  output logic              pf_set,
  output logic              sqw_out,
  output logic              upd_req
);
  localparam logic [TAP_W-1:0] SEC_TAP = TAP_W'(CHAIN_W - 1);

  logic [CHAIN_W-1:0] cnt;
  logic               adv;
  logic               rate_on;
  logic [TAP_W-1:0]   rate_tap;

  assign rate_on  = (rate_sel != '0);
  assign rate_tap = tap_of_rate(rate_sel);

  div_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_ctl(div_ctl),
    .cnt(cnt), .adv(adv)
  );

  tap_rise u_periodic (
    .clk(clk), .rst_n(rst_n), .adv(adv), .en(rate_on),
    .cnt(cnt), .tap(rate_tap), .pulse(pf_set)
  );

  tap_rise u_second (
    .clk(clk), .rst_n(rst_n), .adv(adv), .en(1'b1),
    .cnt(cnt), .tap(SEC_TAP), .pulse(upd_req)
  );

  assign sqw_out = rst_n && sqw_en && rate_on && cnt[rate_tap];

  p_sqw_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |-> !sqw_out);
  p_rate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rate_sel) == '0) |-> !pf_set);
  p_pf_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |=> !pf_set);
  p_upd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> !upd_req);
  p_upd_when_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |-> ($past(div_ctl) == 3'b010));
endmodule

// File: tb/rtc_divchain_test.sv
module rtc_divchain_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [2:0] div_ctl = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0;
  logic       pf_set, sqw_out, upd_req;

  int tests = 0;
  int fails = 0;
  int n_model = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit seen = 1'b0;

  typedef struct packed {logic pf; logic upd; logic sqw;} exp_t;
  exp_t q[$];

  rtc_divchain uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_ctl(div_ctl),
    .rate_sel(rate_sel), .sqw_en(sqw_en),
    .pf_set(pf_set), .sqw_out(sqw_out), .upd_req(upd_req)
  );

  always #4 clk = ~clk;

  function automatic int period_of(input logic [3:0] code);
    int f;
    case (code)
      4'd1:    f = 256;
      4'd2:    f = 128;
      default: f = 65536 >> code;
    endcase
    return 32768 / f;
  endfunction

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at cycle %0d",
               req, what, act, exp, cycles);
    end
  endtask

  // Driver: one time-base pulse, expected results pushed to the scoreboard
  task automatic do_tick();
    exp_t e;
    bit   advanced;
    int   p;
    advanced = (div_ctl == 3'b010);
    if (advanced) n_model++;
    else if (div_ctl[2:1] == 2'b11) n_model = 0;
    p = (rate_sel != 0) ? period_of(rate_sel) : 1;
    e.pf  = advanced && rate_sel != 0 && (n_model % p) == p / 2;
    e.upd = advanced && (n_model % 32768) == 16384;
    e.sqw = sqw_en && rate_sel != 0 && (n_model % p) >= p / 2;
    q.push_back(e);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_ticks(input int count);
    for (int i = 0; i < count; i++) do_tick();
  endtask

  task automatic set_ctl(input logic [2:0] c);
    div_ctl = c;
    if (c[2:1] == 2'b11) n_model = 0;
    @(negedge clk);
  endtask

  // Monitor
  always @(posedge clk) begin
    seen <= tick_en;
    cycles <= cycles + 1;
  end

  always @(negedge clk) begin
    exp_t e;
    if (started) begin
      if (seen) begin
        if (q.size() == 0) begin
          check("R2", "scoreboard empty", 1'b1, 1'b0);
        end else begin
          e = q.pop_front();
          check("R2", "pf_set", pf_set, e.pf);
          check("R5", "upd_req", upd_req, e.upd);
          check("R4", "sqw_out", sqw_out, e.sqw);
        end
      end else begin
        check("R2", "pf_set idle", pf_set, 1'b0);
        check("R5", "upd_req idle", upd_req, 1'b0);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    sqw_en = 1'b1;
    rate_sel = 4'd3;
    // R8: outputs low in reset even with enables set
    check("R8", "sqw_out in reset", sqw_out, 1'b0);
    check("R8", "pf_set in reset", pf_set, 1'b0);
    check("R8", "upd_req in reset", upd_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1'b1;
    // R2/R4: fast rate 8192 Hz, then 1024 Hz
    set_ctl(3'b010);
    run_ticks(40);
    rate_sel = 4'd6;
    run_ticks(300);
    // R7/R1: freeze with codes 000, 011, 100, then continue
    set_ctl(3'b000);
    run_ticks(20);
    set_ctl(3'b011);
    run_ticks(20);
    set_ctl(3'b100);
    run_ticks(20);
    set_ctl(3'b010);
    run_ticks(100);
    // R3: rate code 0
    rate_sel = 4'd0;
    run_ticks(100);
    // R8: square wave disabled, periodic still running
    rate_sel = 4'd4;
    sqw_en = 1'b0;
    run_ticks(40);
    sqw_en = 1'b1;
    // R6: hold with 110 and 111, then release
    set_ctl(3'b110);
    run_ticks(10);
    set_ctl(3'b111);
    run_ticks(10);
    set_ctl(3'b010);
    // R5: first update 16384 pulses after release, R2 at 256 Hz
    rate_sel = 4'd1;
    run_ticks(17000);
    // R2 at 128 Hz and 2 Hz, R5 second update
    rate_sel = 4'd2;
    run_ticks(16000);
    rate_sel = 4'd15;
    run_ticks(17000);
    @(negedge clk);
    check("R5", "scoreboard drained", q.size() == 0, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule